// File: doc/BRIEF.md
# Single-Clock FIFO with Show-Ahead Output

This block is a first-in first-out buffer in which writes, reads and all flags share one rising-edge clock. A producer offers a word together with a write request, and a consumer pulls words with a read request. The block reports full and empty, threshold-based almost-full and almost-empty, and the number of stored words. Overflow and underflow protection can each be turned off. An optional mode accepts a write into a full buffer when a read is made in the same cycle.

Two output styles are fixed at elaboration. In normal mode the output register loads a word only when a read is accepted. In show-ahead mode the oldest stored word is already on the output, and a read moves the output on to the next word. An optional output register can be added in either mode. The block has an asynchronous clear and a synchronous clear. Neither clear changes a registered output.

Occupancy is tracked by a three-state machine: `ST_EMPTY`, `ST_MID` and `ST_FULL`. The transitions are:
- FILL_START: `ST_EMPTY` to `ST_MID` on an accepted write.
- TOP_OFF: `ST_MID` to `ST_FULL` on a write with no read while DEPTH-1 words are stored.
- DRAIN_LAST: `ST_MID` to `ST_EMPTY` on a read with no write while one word is stored.
- SPILL: `ST_FULL` to `ST_MID` on a read with no write.
- CLEAR: any state to `ST_EMPTY` on either clear.

Top module: `sc_fifo`

## Requirements
- R1: Accepted words leave the buffer in the order they were accepted, and no word is lost or repeated.
- R2: With overflow checking on, a write request while full is ignored, unless the write-while-full option is on and a read is accepted in the same cycle.
- R3: With underflow checking on, a read request while empty is ignored. Count, flags and output do not change.
- R4: `almost_full` is 1 exactly while the stored count is greater than or equal to AF_LEVEL.
- R5: `almost_empty` is 1 exactly while the stored count is less than or equal to AE_LEVEL.
- R6: In normal mode without an output register, `q` shows the word taken by an accepted read from the edge that accepts the read, and holds its value at every other edge.
- R7: In show-ahead mode, whenever the buffer is not empty, `q` shows the oldest stored word, and an accepted read advances `q` to the next word at that edge.
- R8: `usedw` equals the stored count modulo 2^UW, where UW = ceil(log2(DEPTH)); it therefore reads 0 when a power-of-two DEPTH is full. A cycle with both a write and a read accepted leaves the count unchanged. `full` and `empty` are never both 1.
- R9: `sclr` sampled high at a rising edge empties the buffer at that edge: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `usedw`=0. Any request in that same cycle is dropped.
- R10: `aclr` high empties the buffer and sets the same flag values as R9 at once, without waiting for a clock edge.
- R11: Neither clear changes a registered `q`. The last value shown stays until a later read or write moves it.
- R12: With the write-while-full option on and overflow checking on, a write and a read on a full buffer are both accepted, and the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| aclr | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, active high |
| wrreq | input | 1 | Write request |
| wdata | input | WIDTH | Word to store |
| rdreq | input | 1 | Read request (in show-ahead mode, advances to the next word) |
| q | output | WIDTH | Output word |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no word |
| almost_full | output | 1 | Count >= AF_LEVEL |
| almost_empty | output | 1 | Count <= AE_LEVEL |
| usedw | output | UW | Stored count modulo 2^UW |

## Verification
The bench drives two instances from the same stimulus. One is in normal mode with write-while-full enabled; the other is in registered show-ahead mode with write-while-full disabled. It aims at the full boundary with a simultaneous read, and at the empty boundary with a simultaneous write. At those boundaries, a design with the wrong acceptance rule would drop or duplicate a word, or its count would drift away from the reference queue. It also checks that a full buffer with power-of-two depth reads a count of 0. It places a synchronous clear and an asynchronous clear in the middle of live traffic. A design that let a request through under clear, waited for the clock on the asynchronous path, or wiped the output register would differ from the model at once. Finally, it compares the show-ahead bypass case, where a word written into an empty or nearly empty buffer must become the head at the same edge.

// File: rtl/sc_fifo_pkg.sv
package sc_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_MID   = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/sc_fifo_ctrl.sv
module sc_fifo_ctrl
    import sc_fifo_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int AF_LEVEL     = 6,
    parameter int AE_LEVEL     = 2,
    parameter bit OVF_CHECK    = 1'b1,
    parameter bit UNF_CHECK    = 1'b1,
    parameter bit WR_WHEN_FULL = 1'b0,
    parameter int PW           = $clog2(DEPTH),
    parameter int CW           = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          sclr,
    input  logic          wrreq,
    input  logic          rdreq,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] rd_ptr_nxt,
    output logic          nonempty_nxt,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic [PW-1:0] usedw
);

    occ_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [PW-1:0] wr_ptr_n;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Request acceptance
    always_comb begin
        rd_ok = rdreq && !sclr && (!UNF_CHECK || st != ST_EMPTY);
        wr_ok = wrreq && !sclr &&
                (!OVF_CHECK || st != ST_FULL || (WR_WHEN_FULL && rd_ok));
    end

    // Next-state and next-count logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_EMPTY: if (wr_ok) st_n = ST_MID;
            ST_MID: begin
                if (wr_ok && !rd_ok && cnt == CW'(DEPTH - 1))
                    st_n = ST_FULL;
                else if (rd_ok && !wr_ok && cnt == CW'(1))
                    st_n = ST_EMPTY;
            end
            ST_FULL:  if (rd_ok && !wr_ok) st_n = ST_MID;
            default:  st_n = ST_EMPTY;
        endcase
        if (sclr) st_n = ST_EMPTY;

        unique case ({wr_ok, rd_ok})
            2'b10:   cnt_n = cnt + 1'b1;
            2'b01:   cnt_n = cnt - 1'b1;
            default: cnt_n = cnt;
        endcase
        if (sclr) cnt_n = '0;

        wr_ptr_n   = wr_ok ? bump(wr_ptr) : wr_ptr;
        rd_ptr_nxt = rd_ok ? bump(rd_ptr) : rd_ptr;
        if (sclr) begin
            wr_ptr_n   = '0;
            rd_ptr_nxt = '0;
        end
        nonempty_nxt = (cnt_n != '0);
    end

    // State register
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            st     <= ST_EMPTY;
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            wr_ptr <= wr_ptr_n;
            rd_ptr <= rd_ptr_nxt;
        end
    end

    // Flag outputs
    always_comb begin
        full         = (st == ST_FULL);
        empty        = (st == ST_EMPTY);
        almost_full  = (int'(cnt) >= AF_LEVEL);
        almost_empty = (int'(cnt) <= AE_LEVEL);
        usedw        = cnt[PW-1:0];
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (aclr)
        (full && wrreq && !rdreq && !sclr) |=> (full && $stable(wr_ptr)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (aclr)
        (empty && rdreq && !wrreq && !sclr) |=> (empty && $stable(rd_ptr)));

    p_sclr_r9: assert property (@(posedge clk) disable iff (aclr)
        sclr |=> (empty && !full && usedw == '0));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (aclr)
        (wr_ok && rd_ok) |=> $stable(usedw));

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (aclr)
        !(full && empty));

    p_wr_full_r12: assert property (@(posedge clk) disable iff (aclr)
        (WR_WHEN_FULL && OVF_CHECK && full && wrreq && rdreq && !sclr) |=> full);

endmodule

// File: rtl/sc_fifo_store.sv
module sc_fifo_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr_a,
    input  logic [PW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/sc_fifo_out.sv
module sc_fifo_out #(
    parameter int WIDTH      = 8,
    parameter int PW         = 3,
    parameter bit SHOW_AHEAD = 1'b0,
    parameter bit OUT_REG    = 1'b0
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             rd_ok,
    input  logic             wr_ok,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [PW-1:0]    rd_ptr_nxt,
    input  logic             nonempty_nxt,
    input  logic [WIDTH-1:0] head_now,
    input  logic [WIDTH-1:0] head_nxt_mem,
    output logic [WIDTH-1:0] q
);

    generate
        if (!SHOW_AHEAD) begin : g_normal
            logic [WIDTH-1:0] data_r;
            always_ff @(posedge clk) begin
                if (rd_ok) data_r <= head_now;
            end
            if (OUT_REG) begin : g_reg
                logic [WIDTH-1:0] q_r;
                always_ff @(posedge clk) q_r <= data_r;
                assign q = q_r;
            end else begin : g_direct
                assign q = data_r;
                p_hold_r6: assert property (@(posedge clk) disable iff (aclr)
                    !rd_ok |=> $stable(q));
            end
        end else begin : g_show
            if (OUT_REG) begin : g_reg
                logic [WIDTH-1:0] q_r;
                logic [WIDTH-1:0] head_n;
                always_comb begin
                    head_n = (wr_ok && rd_ptr_nxt == wr_ptr) ? wdata : head_nxt_mem;
                end
                always_ff @(posedge clk) begin
                    if (nonempty_nxt) q_r <= head_n;
                end
                assign q = q_r;
            end else begin : g_direct
                assign q = head_now;
            end
        end
    endgenerate

endmodule

// File: rtl/sc_fifo.sv
module sc_fifo #(
    parameter int WIDTH        = 8,
    parameter int DEPTH        = 8,
    parameter int AF_LEVEL     = DEPTH - 2,
    parameter int AE_LEVEL     = 2,
    parameter bit SHOW_AHEAD   = 1'b0,
    parameter bit OUT_REG      = 1'b0,
    parameter bit OVF_CHECK    = 1'b1,
    parameter bit UNF_CHECK    = 1'b1,
    parameter bit WR_WHEN_FULL = 1'b0,
    parameter int UW           = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             sclr,
    input  logic             wrreq,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rdreq,
    output logic [WIDTH-1:0] q,
    output logic             full,
    output logic             empty,
    output logic             almost_full,
    output logic             almost_empty,
    output logic [UW-1:0]    usedw
);

    localparam int CW = $clog2(DEPTH + 1);

    logic             wr_ok, rd_ok, nonempty_nxt;
    logic [UW-1:0]    wr_ptr, rd_ptr, rd_ptr_nxt;
    logic [WIDTH-1:0] head_now, head_nxt_mem;

    sc_fifo_ctrl #(
        .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL),
        .OVF_CHECK(OVF_CHECK), .UNF_CHECK(UNF_CHECK),
        .WR_WHEN_FULL(WR_WHEN_FULL), .PW(UW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wrreq(wrreq), .rdreq(rdreq),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .rd_ptr_nxt(rd_ptr_nxt), .nonempty_nxt(nonempty_nxt),
        .full(full), .empty(empty), .almost_full(almost_full),
        .almost_empty(almost_empty), .usedw(usedw)
    );

    sc_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(UW)) u_store (
        .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wdata),
        .raddr_a(rd_ptr), .raddr_b(rd_ptr_nxt),
        .rdata_a(head_now), .rdata_b(head_nxt_mem)
    );

    sc_fifo_out #(
        .WIDTH(WIDTH), .PW(UW), .SHOW_AHEAD(SHOW_AHEAD), .OUT_REG(OUT_REG)
    ) u_out (
        .clk(clk), .aclr(aclr), .rd_ok(rd_ok), .wr_ok(wr_ok), .wdata(wdata),
        .wr_ptr(wr_ptr), .rd_ptr_nxt(rd_ptr_nxt), .nonempty_nxt(nonempty_nxt),
        .head_now(head_now), .head_nxt_mem(head_nxt_mem), .q(q)
    );

endmodule

// File: tb/sc_fifo_tb.sv
module sc_fifo_tb;

    localparam int W  = 8;
    localparam int D  = 8;
    localparam int AF = 6;
    localparam int AE = 2;
    localparam int UW = 3;

    logic clk = 1'b0;
    logic aclr = 1'b1, sclr = 1'b0, wrreq = 1'b0, rdreq = 1'b0;
    logic [W-1:0] wdata = '0;

    logic [W-1:0]  q_n, q_s;
    logic          full_n, empty_n, af_n, ae_n, full_s, empty_s, af_s, ae_s;
    logic [UW-1:0] used_n, used_s;

    always #4 clk = ~clk;

    // normal mode, write-while-full on
    sc_fifo #(.WIDTH(W), .DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE),
              .SHOW_AHEAD(1'b0), .OUT_REG(1'b0), .WR_WHEN_FULL(1'b1)) u_dut (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wrreq(wrreq), .wdata(wdata),
        .rdreq(rdreq), .q(q_n), .full(full_n), .empty(empty_n),
        .almost_full(af_n), .almost_empty(ae_n), .usedw(used_n));

    // registered show-ahead mode, write-while-full off
    sc_fifo #(.WIDTH(W), .DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE),
              .SHOW_AHEAD(1'b1), .OUT_REG(1'b1), .WR_WHEN_FULL(1'b0)) u_dut_sa (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wrreq(wrreq), .wdata(wdata),
        .rdreq(rdreq), .q(q_s), .full(full_s), .empty(empty_s),
        .almost_full(af_s), .almost_empty(ae_s), .usedw(used_s));

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    logic [W-1:0] mq_n[$], mq_s[$];
    logic [W-1:0] eq_n, eq_s;
    bit eqv_n = 1'b0, eqv_s = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [W-1:0] seq = 8'h10;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int sn = mq_n.size();
        int ss = mq_s.size();
        chk(full_n == (sn == D), "R2", "full_n", full_n, sn == D);
        chk(empty_n == (sn == 0), "R3", "empty_n", empty_n, sn == 0);
        chk(af_n == (sn >= AF), "R4", "af_n", af_n, sn >= AF);
        chk(ae_n == (ss >= 0 && sn <= AE), "R5", "ae_n", ae_n, sn <= AE);
        chk(int'(used_n) == sn % (1 << UW), "R8", "used_n", used_n, sn % (1 << UW));
        chk(full_s == (ss == D), "R2", "full_s", full_s, ss == D);
        chk(empty_s == (ss == 0), "R3", "empty_s", empty_s, ss == 0);
        chk(af_s == (ss >= AF), "R4", "af_s", af_s, ss >= AF);
        chk(ae_s == (ss <= AE), "R5", "ae_s", ae_s, ss <= AE);
        chk(int'(used_s) == ss % (1 << UW), "R8", "used_s", used_s, ss % (1 << UW));
        if (eqv_n) chk(q_n == eq_n, "R6", "q_n", q_n, eq_n);
        if (eqv_s) chk(q_s == eq_s, "R7", "q_s", q_s, eq_s);
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit wr, input bit rd, input bit sc);
        bit rn, wn, rs, ws;
        wrreq = wr; rdreq = rd; sclr = sc;
        if (wr) begin wdata = seq; end
        @(posedge clk);
        if (sc) begin
            mq_n.delete(); mq_s.delete();
        end else begin
            rn = rd && mq_n.size() > 0;
            wn = wr && (mq_n.size() < D || rn);
            rs = rd && mq_s.size() > 0;
            ws = wr && mq_s.size() < D;
            if (rn) begin eq_n = mq_n.pop_front(); eqv_n = 1'b1; end
            if (wn) mq_n.push_back(wdata);
            if (rs) void'(mq_s.pop_front());
            if (ws) mq_s.push_back(wdata);
            if (mq_s.size() > 0) begin eq_s = mq_s[0]; eqv_s = 1'b1; end
        end
        if (wr) seq = seq + 8'd7;
        @(negedge clk);
        compare_all();
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state while aclr held (R10)
        chk(empty_n && ae_n && !full_n && !af_n && used_n == 0, "R10", "reset_n", empty_n, 1);
        chk(empty_s && ae_s && !full_s && !af_s && used_s == 0, "R10", "reset_s", empty_s, 1);
        aclr = 1'b0;
        @(negedge clk);
        compare_all();

        // R3: reads on empty are ignored
        repeat (3) cyc(1'b0, 1'b1, 1'b0);
        // R1/R4/R5: fill to full; R8: full count wraps to 0
        for (int i = 0; i < D; i++) cyc(1'b1, 1'b0, 1'b0);
        chk(full_n && used_n == 0, "R8", "full_wrap", used_n, 0);
        // R2: write while full, no read
        repeat (2) cyc(1'b1, 1'b0, 1'b0);
        // R12: write and read on full (u_dut accepts both, u_dut_sa only reads)
        repeat (3) cyc(1'b1, 1'b1, 1'b0);
        chk(full_n == 1'b1, "R12", "full_kept", full_n, 1);
        // drain past empty (R1, R3)
        repeat (D + 3) cyc(1'b0, 1'b1, 1'b0);
        // back-to-back write+read at empty (show-ahead bypass, R7)
        repeat (4) cyc(1'b1, 1'b1, 1'b0);
        // R8: simultaneous traffic mid-level keeps count
        repeat (3) cyc(1'b1, 1'b0, 1'b0);
        repeat (6) cyc(1'b1, 1'b1, 1'b0);

        // mixed stream
        for (int k = 0; k < 400; k++) begin
            step_lfsr();
            cyc(lfsr[0] | (lfsr[5] & k[6]), lfsr[3] | (lfsr[7] & ~k[6]), 1'b0);
        end

        // R9/R11: synchronous clear with requests active
        repeat (5) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        chk(empty_n && empty_s && used_n == 0 && used_s == 0, "R9", "sclr_flags", empty_n, 1);
        chk(q_n == eq_n && q_s == eq_s, "R11", "sclr_q_kept", q_s, eq_s);
        repeat (3) cyc(1'b0, 1'b1, 1'b0);

        // R10/R11: asynchronous clear mid-stream
        repeat (6) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        wrreq = 1'b0; rdreq = 1'b0;
        #1 aclr = 1'b1;
        #1;
        chk(empty_n && ae_n && !full_n && !af_n && used_n == 0, "R10", "aclr_now_n", used_n, 0);
        chk(empty_s && ae_s && !full_s && !af_s && used_s == 0, "R10", "aclr_now_s", used_s, 0);
        chk(q_n == eq_n, "R11", "aclr_q_n", q_n, eq_n);
        chk(q_s == eq_s, "R11", "aclr_q_s", q_s, eq_s);
        mq_n.delete(); mq_s.delete();
        @(negedge clk);
        aclr = 1'b0;
        @(negedge clk);
        compare_all();

        // resume after clear (R1)
        for (int k = 0; k < 200; k++) begin
            step_lfsr();
            cyc(lfsr[1], lfsr[2] & lfsr[4], 1'b0);
        end
        repeat (D + 2) cyc(1'b0, 1'b1, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule